// File: doc/BRIEF.md
# Look-Ahead Flag FIFO

A single-clock first-in first-out buffer. It is built from four parts: a write pointer, a read pointer, a dual-port word store, and a small flag state machine. A producer raises `wr_en` with a word on `wr_data`. A consumer watches `rd_data`, which always shows the oldest stored word without any read latency, and raises `rd_en` to retire that word. Addresses wrap modulo `DEPTH`. One slot is always left unused, so the buffer holds at most `DEPTH-1` words and the full and empty pointer relations can never be the same.

The `full` and `empty` flags come straight from the state register. The state machine decides the next value one cycle ahead. It looks at the pointer relation together with the request seen in the current cycle, so each flag is already correct in the first cycle in which it applies.

- **Write only** into a buffer that is one word short of capacity: the write pointer is two behind the read pointer, and the machine moves to FULL.
- **Read only** that removes the last word: the write pointer is one ahead of the read pointer, and the machine moves to EMPTY.

The three states are:

- **ST_EMPTY**: nothing is stored.
- **ST_PARTIAL**: some words are stored and there is free space.
- **ST_FULL**: `DEPTH-1` words are stored.

The named transitions are:

| Name | From | To | Cause |
|---|---|---|---|
| FILL_FIRST | ST_EMPTY | ST_PARTIAL | a write |
| TOP_OFF | ST_PARTIAL | ST_FULL | a write only, with write pointer plus 2 equal to read pointer |
| FILL_FIRST with TOP_OFF | ST_EMPTY | ST_FULL | a write, when `DEPTH` is 2 |
| DRAIN_LAST | ST_PARTIAL | ST_EMPTY | a read only, with write pointer minus 1 equal to read pointer |
| RELEASE | ST_FULL | ST_PARTIAL | a read |
| RELEASE with DRAIN_LAST | ST_FULL | ST_EMPTY | a read, when `DEPTH` is 2 |

Every other case holds the current state.

Top module: `fifo_la`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `empty`=1 and `full`=0.
- R2: Words leave in exactly the order they were accepted.
- R3: Whenever `empty`=0, `rd_data` equals the oldest stored word. After a write into an empty buffer, that word appears in the very next cycle.
- R4: The buffer holds `DEPTH-1` words. `full` rises in the cycle right after the write-only cycle that stores word number `DEPTH-1`.
- R5: `empty` rises in the cycle right after the read-only cycle that removes the last word.
- R6: A write while `full`=1 is dropped. The stored words and the flags stay the same.
- R7: A read while `empty`=1 is dropped. The flags stay the same, and later data is not disturbed.
- R8: A cycle that both reads and writes, with neither flag set, keeps the occupancy the same, and both flags hold.
- R9: Reading and writing together while `full`=1 performs only the read, so `full` falls. Doing so while `empty`=1 performs only the write, so `empty` falls.
- R10: The pointers wrap modulo `DEPTH`, and ordering stays correct across many wraps.
- R11: `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request: retire the head word |
| rd_data | output | DW | Head word; meaningful only while `empty` is 0 |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |

## Verification
The assertions take for granted that `wr_en` and `rd_en` carry known 0/1 values at every rising edge after reset. Their occupancy counter counts a request as accepted only when the corresponding flag is clear. The assertions place no constraint on `wr_data`.

The bench changes its inputs only at falling edges and always drives both requests to 0 or 1. It compares `rd_data` only while its own model holds at least one word. It also issues writes while full and reads while empty on purpose, so that the blocking paths are exercised.

// File: rtl/fifo_la_pkg.sv
package fifo_la_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/fifo_la_ptr.sv
module fifo_la_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] INC = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + INC;
        end
    end

endmodule

// File: rtl/fifo_la_mem.sv
module fifo_la_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/fifo_la_flag_fsm.sv
module fifo_la_flag_fsm
    import fifo_la_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [AW-1:0] wa,
    input  logic [AW-1:0] ra,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    fill_state_t state_q, state_d;
    logic        one_short;
    logic        one_left;

    // look-ahead pointer relations
    assign one_short = ((wa + TWO) == ra);
    assign one_left  = ((wa - ONE) == ra);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                // FILL_FIRST (direct TOP_OFF when only one slot exists)
                if (wr_req) begin
                    state_d = one_short ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (wr_req && !rd_req && one_short) begin
                    state_d = ST_FULL;         // TOP_OFF
                end else if (rd_req && !wr_req && one_left) begin
                    state_d = ST_EMPTY;        // DRAIN_LAST
                end
            end
            ST_FULL: begin
                // RELEASE (direct DRAIN_LAST when only one slot exists)
                if (rd_req) begin
                    state_d = one_left ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        full  = (state_q == ST_FULL);
        empty = (state_q == ST_EMPTY);
        wr_ok = wr_req && (state_q != ST_FULL);
        rd_ok = rd_req && (state_q != ST_EMPTY);
    end

endmodule

// File: rtl/fifo_la.sv
module fifo_la #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wa;
    logic [AW-1:0] ra;
    logic          wr_ok;
    logic          rd_ok;

    fifo_la_ptr #(.AW(AW)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .step (wr_ok),
        .addr (wa)
    );

    fifo_la_ptr #(.AW(AW)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .step (rd_ok),
        .addr (ra)
    );

    fifo_la_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wa),
        .wdata (wr_data),
        .raddr (ra),
        .rdata (rd_data)
    );

    fifo_la_flag_fsm #(.AW(AW)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .wa     (wa),
        .ra     (ra),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .full   (full),
        .empty  (empty)
    );

endmodule

// File: rtl/fifo_la_chk.sv
module fifo_la_chk #(
    parameter int AW    = 4,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [AW-1:0] wa,
    input logic [AW-1:0] ra
);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH - 1);

    logic [AW:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            unique case ({wr_en && !full, rd_en && !empty})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    a_r1_reset_flags: assert property (@(posedge clk)
        rst |=> (empty && !full));

    a_r4_full_at_cap: assert property (@(posedge clk) disable iff (rst)
        full == (occ == CAP));

    a_r5_empty_at_zero: assert property (@(posedge clk) disable iff (rst)
        empty == (occ == '0));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(wa));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(ra));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> ($stable(full) && $stable(empty)));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

bind fifo_la fifo_la_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .full  (full),
    .empty (empty),
    .wa    (wa),
    .ra    (ra)
);

// File: tb/sim_fifo_la.sv
module sim_fifo_la;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int DEPTH      = 16;
    localparam int CAP        = DEPTH - 1;

    logic          clk     = 1'b0;
    logic          rst     = 1'b1;
    logic          wr_en   = 1'b0;
    logic          rd_en   = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full;
    logic          empty;

    int            checks = 0;
    int            bad    = 0;
    bit            done   = 0;
    string         tag    = "R1";
    logic [DW-1:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_la #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .full    (full),
        .empty   (empty)
    );

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", t, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk({tag, " R11 flags exclusive"}, 32'(full & empty), 32'd0);
        chk({tag, " empty"}, 32'(empty), 32'(model.size() == 0));
        chk({tag, " full"}, 32'(full), 32'(model.size() == CAP));
        if (model.size() > 0) begin
            chk({tag, " R3 head data"}, 32'(rd_data), 32'(model[0]));
        end
    endtask

    // drive at falling edge, model the accepted operations, compare at next falling edge
    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        bit take_w;
        bit take_r;
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        @(posedge clk);
        take_w = w && (model.size() < CAP);
        take_r = r && (model.size() > 0);
        if (take_r) void'(model.pop_front());
        if (take_w) model.push_back(d);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 empty in reset", 32'(empty), 32'd1);
        chk("R1 full in reset", 32'(full), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        compare();

        // R7: reads on an empty buffer are dropped
        tag = "R7";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h00);

        // R3: first word falls through in the next cycle
        tag = "R3";
        step(1'b1, 1'b0, 8'hA5);
        chk("R3 fall-through", 32'(rd_data), 32'hA5);

        // R4: fill to capacity, full rises right after the last write
        tag = "R4";
        for (int i = 1; i < CAP; i++) step(1'b1, 1'b0, 8'(8'h10 + i));
        chk("R4 full after last slot", 32'(full), 32'd1);

        // R6: writes while full are dropped
        tag = "R6";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'hEE);
        chk("R6 head unchanged", 32'(rd_data), 32'hA5);

        // R9: read and write while full performs only the read
        tag = "R9";
        step(1'b1, 1'b1, 8'hCC);
        chk("R9 full falls", 32'(full), 32'd0);

        // R5, R2: drain in order until empty
        tag = "R5";
        while (model.size() > 0) step(1'b0, 1'b1, 8'h00);
        chk("R5 empty after last read", 32'(empty), 32'd1);

        // R9: read and write while empty performs only the write
        tag = "R9";
        step(1'b1, 1'b1, 8'h3C);
        chk("R9 empty falls", 32'(empty), 32'd0);
        chk("R9 written word at head", 32'(rd_data), 32'h3C);

        // R8: simultaneous traffic with a partial fill holds the flags
        tag = "R8";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'h40 + i));
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 8'(8'h80 + i));
        chk("R8 occupancy kept", 32'(empty | full), 32'd0);

        // R10, R2: random traffic over many wraps
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic r;
            w = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 70 : 35));
            r = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 35 : 70));
            step(w, r, 8'($urandom));
        end

        tag = "R2";
        while (model.size() > 0) step(1'b0, 1'b1, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule